// File: doc/BRIEF.md
# Microcontroller Interrupt Control Unit

This block is the interrupt controller of a small CPU. It has four interrupt sources: an edge on an external pin, a pulse from an 8-bit timer when it wraps from 0xFF to 0x00, a change on any of the upper four port pins, and a completed nonvolatile write. The first three are latched as flags in an 8-bit control/status register. The write-complete flag is kept in another register and arrives here as a level. Each source is masked by its own enable bit. The sum of the masked sources is then gated by a global enable. A flag sets on its event whatever the state of the masks. Software reads the register to find the source, and it writes the register to clear the flags.

A sequencer samples the request once per instruction cycle, on the `cyc_q1` strobe. When the request is accepted, the sequencer lets the current instruction finish. On the next strobe it pulses a vector load to address 0x0004 together with a return-address push, and it clears the global enable. It then holds a dummy cycle for one instruction cycle. A return-from-interrupt strobe sets the global enable again. While the CPU sleeps, `wake` follows the masked sources alone, without the global enable. Once the CPU has woken, the global enable decides whether it vectors or continues.

The sequencer has four states. ST_RUN is normal execution. ST_SLEEP is the CPU asleep. ST_ACK is the request accepted while the current instruction completes. ST_DUMMY is the dummy cycle after the vector load. All transitions happen on a strobe. They are: RUN→SLEEP when `asleep` is high, RUN→ACK when the request is pending and the CPU is awake, SLEEP→RUN when `asleep` is low, ACK→DUMMY always (this transition issues the vector load and the push), and DUMMY→RUN always.

Top module: `irq_ctrl_unit`

## Requirements
- R1: After reset the register reads 0x00, so the global enable is clear. `irq_req`, `wake`, `vec_load`, `push_ret` and `dummy_cyc` are low.
- R2: The register bits are: 7 global enable, 6 write-complete enable, 5 timer enable, 4 pin enable, 3 port-change enable, 2 timer flag, 1 pin flag, 0 port-change flag. A write stores all eight bits, and `reg_rdata` returns them.
- R3: A `tmr_ovf` pulse sets bit 2 even when every enable bit and the global enable are clear.
- R4: With `edge_rise`=1 a rising edge of `ext_pin` sets bit 1, and with `edge_rise`=0 a falling edge sets it. The opposite edge has no effect. The flag is visible SYNC_STAGES+1 clocks after the pin changes.
- R5: Any change in the value of `port_hi` sets bit 0.
- R6: If a register write and a hardware event hit the same flag in the same clock, the flag ends up set.
- R7: `irq_req` changes only on a clock where `cyc_q1` is high. There it takes the value of global enable AND the OR of (bit2&bit5, bit1&bit4, bit0&bit3, `nvw_flag`&bit6).
- R8: An accepted request gives a one-clock pulse of `vec_load` and `push_ret`, with `vec_addr`=0x0004. This happens 3 clocks after `irq_req` first shows high (one instruction cycle of 4 clocks after the sampling strobe), and it clears bit 7 while the flags stay set.
- R9: `dummy_cyc` is high for the instruction cycle that follows the vector load and low afterwards.
- R10: A `reti` pulse sets bit 7. If a masked flag is still set, a new vector follows.
- R11: While `asleep` is high, `wake` equals the OR of the masked sources regardless of bit 7, and no vector is issued.
- R12: After `asleep` falls, the CPU vectors if bit 7 is set. If bit 7 is clear it continues without a vector, and the flags are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_q1 | input | 1 | One-clock strobe per instruction cycle; the request is sampled here |
| asleep | input | 1 | CPU is in sleep |
| ext_pin | input | 1 | External interrupt pin (asynchronous) |
| edge_rise | input | 1 | 1: rising edge active, 0: falling edge active |
| port_hi | input | PORT_W | Upper port pins watched for change (asynchronous) |
| tmr_ovf | input | 1 | One-clock pulse on timer wrap 0xFF→0x00 |
| nvw_flag | input | 1 | Write-complete flag level from its own register |
| reg_wr | input | 1 | Write strobe for the control/status register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Register contents |
| reti | input | 1 | Return-from-interrupt strobe |
| irq_req | output | 1 | Interrupt request as sampled at the last strobe |
| wake | output | 1 | Wake-up request while asleep |
| vec_load | output | 1 | Load the program counter with `vec_addr` |
| push_ret | output | 1 | Push the return address |
| vec_addr | output | ADDR_W | Interrupt vector, 0x0004 |
| dummy_cyc | output | 1 | Dummy instruction cycle in progress |

## Verification
The bench targets the race between a software clear and a hardware event on the same flag. A design that gives the write priority loses the event. It checks the opposite pin edge and the flag kept set while masked: a wrong polarity decode sets the flag on the wrong edge, and a design that gates flags with the enables never shows the flag. It stops the strobe to show that the request cannot move between samples. It measures the exact clock distance from request to vector, so an extra or a missing pipeline stage shows up as wrong latency. It also covers sleep with the global enable both clear and set. A design that uses the global enable in the wake term never wakes. One that vectors during sleep, or after waking with the global enable clear, produces a vector that the scoreboard did not expect.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_SLEEP = 2'd1,
        ST_ACK   = 2'd2,
        ST_DUMMY = 2'd3
    } seq_state_t;

    localparam int REG_W        = 8;
    localparam int NUM_HW_FLAGS = 3;
    localparam int NUM_EN       = 4;

    localparam int B_GIE = 7;
    localparam int B_WCE = 6;
    localparam int B_TME = 5;
    localparam int B_PNE = 4;
    localparam int B_PCE = 3;
    localparam int B_TMF = 2;
    localparam int B_PNF = 1;
    localparam int B_PCF = 0;

endpackage

// File: rtl/irq_evt_detect.sv
module irq_evt_detect #(
    parameter int SYNC_STAGES = 2,
    parameter int PORT_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_pin,
    input  logic              edge_rise,
    input  logic [PORT_W-1:0] port_hi,
    output logic              pin_evt,
    output logic              port_evt
);
    localparam int SMSB = SYNC_STAGES - 1;

    logic [SMSB:0]       pin_sync;
    logic                pin_last;
    logic [PORT_W-1:0]   port_cur;
    logic [PORT_W-1:0]   port_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_sync <= '0;
            pin_last <= 1'b0;
        end else begin
            pin_sync <= {pin_sync[SMSB-1:0], ext_pin};
            pin_last <= pin_sync[SMSB];
        end
    end

    for (genvar g = 0; g < PORT_W; g++) begin : g_port
        logic [SMSB:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[SMSB-1:0], port_hi[g]};
        end
        assign port_cur[g] = chain[SMSB];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) port_last <= '0;
        else        port_last <= port_cur;
    end

    always_comb begin
        if (edge_rise) pin_evt = pin_sync[SMSB] & ~pin_last;
        else           pin_evt = ~pin_sync[SMSB] & pin_last;
        port_evt = |(port_cur ^ port_last);
    end

endmodule

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg
    import irq_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             set_tmr,
    input  logic             set_pin,
    input  logic             set_port,
    input  logic             nvw_flag,
    input  logic             entry_clr,
    input  logic             reti,
    output logic [REG_W-1:0] ctrl,
    output logic             gie,
    output logic             src_hit
);
    logic                    gie_q;
    logic [NUM_EN-1:0]       en_q;
    logic [NUM_HW_FLAGS-1:0] flag_q;
    logic [NUM_HW_FLAGS-1:0] hw_set;

    assign hw_set = {set_tmr, set_pin, set_port};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gie_q  <= 1'b0;
            en_q   <= '0;
            flag_q <= '0;
        end else begin
            if (reti)           gie_q <= 1'b1;
            else if (entry_clr) gie_q <= 1'b0;
            else if (reg_wr)    gie_q <= reg_wdata[B_GIE];
            if (reg_wr) en_q <= reg_wdata[B_WCE:B_PCE];
            for (int i = 0; i < NUM_HW_FLAGS; i++) begin
                if (hw_set[i])   flag_q[i] <= 1'b1;
                else if (reg_wr) flag_q[i] <= reg_wdata[i];
            end
        end
    end

    always_comb begin
        ctrl    = {gie_q, en_q, flag_q};
        gie     = gie_q;
        src_hit = (|(flag_q & en_q[NUM_HW_FLAGS-1:0])) | (nvw_flag & en_q[NUM_EN-1]);
    end

    // R3: a flag is only ever cleared by a register write
    a_r3_flag_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

    // R6: a hardware set is never lost, even against a write
    a_r6_hw_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_tmr |=> flag_q[B_TMF]);

    // R10: return strobe re-enables
    a_r10_reti_sets: assert property (@(posedge clk) disable iff (!rst_n)
        reti |=> gie_q);

endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
    import irq_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_q1,
    input  logic asleep,
    input  logic pending,
    output logic irq_req,
    output logic vec_load,
    output logic push_ret,
    output logic dummy_cyc
);
    seq_state_t state_q, state_d;
    logic       req_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            req_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (cyc_q1) req_q <= pending;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (cyc_q1) begin
                    if (asleep)       state_d = ST_SLEEP;
                    else if (pending) state_d = ST_ACK;
                end
            end
            ST_SLEEP: if (cyc_q1 && !asleep) state_d = ST_RUN;
            ST_ACK:   if (cyc_q1) state_d = ST_DUMMY;
            ST_DUMMY: if (cyc_q1) state_d = ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    always_comb begin
        irq_req   = req_q;
        vec_load  = 1'b0;
        push_ret  = 1'b0;
        dummy_cyc = 1'b0;
        unique case (state_q)
            ST_ACK: begin
                vec_load = cyc_q1;
                push_ret = cyc_q1;
            end
            ST_DUMMY: dummy_cyc = 1'b1;
            ST_RUN, ST_SLEEP: ;
            default: ;
        endcase
    end

    // R7: request moves only on the sampling strobe
    a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_q1 |=> $stable(irq_req));

    // R9: dummy cycle follows the vector load
    a_r9_dummy_after_vec: assert property (@(posedge clk) disable iff (!rst_n)
        vec_load |=> dummy_cyc);

    // R11: sampling while asleep enters sleep
    a_r11_sleep_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && cyc_q1 && asleep) |=> (state_q == ST_SLEEP));

endmodule

// File: rtl/irq_ctrl_unit.sv
module irq_ctrl_unit
    import irq_ctrl_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int PORT_W      = 4,
    parameter int ADDR_W      = 13,
    parameter logic [ADDR_W-1:0] VECTOR = 13'h0004
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_q1,
    input  logic              asleep,
    input  logic              ext_pin,
    input  logic              edge_rise,
    input  logic [PORT_W-1:0] port_hi,
    input  logic              tmr_ovf,
    input  logic              nvw_flag,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              reti,
    output logic              irq_req,
    output logic              wake,
    output logic              vec_load,
    output logic              push_ret,
    output logic [ADDR_W-1:0] vec_addr,
    output logic              dummy_cyc
);
    logic pin_evt, port_evt;
    logic gie, src_hit, pending;
    logic vec_int;

    irq_evt_detect #(.SYNC_STAGES(SYNC_STAGES), .PORT_W(PORT_W)) u_evt (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .edge_rise(edge_rise),
        .port_hi(port_hi), .pin_evt(pin_evt), .port_evt(port_evt)
    );

    irq_ctrl_reg u_reg (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .set_tmr(tmr_ovf), .set_pin(pin_evt), .set_port(port_evt),
        .nvw_flag(nvw_flag), .entry_clr(vec_int), .reti(reti),
        .ctrl(reg_rdata), .gie(gie), .src_hit(src_hit)
    );

    assign pending = gie & src_hit;

    irq_seq_fsm u_seq (
        .clk(clk), .rst_n(rst_n), .cyc_q1(cyc_q1), .asleep(asleep),
        .pending(pending), .irq_req(irq_req), .vec_load(vec_int),
        .push_ret(push_ret), .dummy_cyc(dummy_cyc)
    );

    assign vec_load = vec_int;
    assign vec_addr = VECTOR;
    assign wake     = asleep & src_hit;

    // R8: entry clears the global enable unless a return strobe coincides
    a_r8_entry_clears_gie: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_load && !reti) |=> !reg_rdata[B_GIE]);

    // R11: no vector while the CPU sleeps
    a_r11_no_vec_asleep: assert property (@(posedge clk) disable iff (!rst_n)
        $past(asleep) && asleep |-> !vec_load);

endmodule

// File: tb/irq_ctrl_unit_test.sv
`timescale 1ns/100ps
module irq_ctrl_unit_test;
    localparam int SYNC = 2;

    logic       clk = 0, rst_n = 0, cyc_q1 = 0, asleep = 0;
    logic       ext_pin = 0, edge_rise = 1, tmr_ovf = 0, nvw_flag = 0;
    logic [3:0] port_hi = 0;
    logic       reg_wr = 0, reti = 0;
    logic [7:0] reg_wdata = 0, reg_rdata;
    logic       irq_req, wake, vec_load, push_ret, dummy_cyc;
    logic [12:0] vec_addr;

    int checks = 0, errors = 0, ph = 0;
    logic strobe_on = 1;
    string exp_q[$];

    irq_ctrl_unit uut (
        .clk(clk), .rst_n(rst_n), .cyc_q1(cyc_q1), .asleep(asleep),
        .ext_pin(ext_pin), .edge_rise(edge_rise), .port_hi(port_hi),
        .tmr_ovf(tmr_ovf), .nvw_flag(nvw_flag), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reti(reti),
        .irq_req(irq_req), .wake(wake), .vec_load(vec_load),
        .push_ret(push_ret), .vec_addr(vec_addr), .dummy_cyc(dummy_cyc)
    );

    always #2.5 clk = ~clk;

    always @(negedge clk) begin
        ph = (ph + 1) % 4;
        cyc_q1 = (ph == 3) && strobe_on;
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr(logic [7:0] v);
        @(negedge clk); reg_wr = 1; reg_wdata = v;
        @(negedge clk); reg_wr = 0; #1;
    endtask

    task automatic pulse_tmr();
        @(negedge clk); tmr_ovf = 1;
        @(negedge clk); tmr_ovf = 0; #1;
    endtask

    task automatic expect_vector(string req);
        exp_q.push_back(req);
    endtask

    // monitor: every vector must have been announced by the driver
    always begin
        @(negedge clk); #1;
        if (rst_n && vec_load) begin
            string tag;
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R11/R12: actual unexpected vector expected none");
            end else begin
                tag = exp_q.pop_front();
                chk({tag, " R8 push"}, push_ret, 1);
                chk({tag, " R8 addr"}, vec_addr, 13'h0004);
            end
            @(negedge clk); #1;
            chk("R9 dummy high", dummy_cyc, 1);
            repeat (4) @(negedge clk); #1;
            chk("R9 dummy low", dummy_cyc, 0);
        end
    end

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int t0, t1;
        tick(4); rst_n = 1; tick(1);
        // R1
        chk("R1 reg", reg_rdata, 8'h00);
        chk("R1 irq", irq_req, 0);
        chk("R1 wake", wake, 0);
        chk("R1 vec", vec_load, 0);
        chk("R1 dummy", dummy_cyc, 0);
        // R2
        wr(8'h7F); chk("R2 readback 7F", reg_rdata, 8'h7F);
        tick(8); chk("R2 no req gie0", irq_req, 0);
        wr(8'h00); chk("R2 readback 00", reg_rdata, 8'h00);
        // R3
        pulse_tmr(); chk("R3 flag unmasked", reg_rdata, 8'h04);
        tick(8); chk("R3 no req", irq_req, 0);
        wr(8'h00);
        // R4 rising mode
        @(negedge clk); ext_pin = 1; tick(SYNC + 2);
        chk("R4 rise sets", reg_rdata[1], 1);
        wr(8'h00);
        @(negedge clk); ext_pin = 0; tick(SYNC + 4);
        chk("R4 fall ignored", reg_rdata[1], 0);
        @(negedge clk); edge_rise = 0; tick(2);
        @(negedge clk); ext_pin = 1; tick(SYNC + 4);
        chk("R4 rise ignored", reg_rdata[1], 0);
        @(negedge clk); ext_pin = 0; tick(SYNC + 2);
        chk("R4 fall sets", reg_rdata[1], 1);
        wr(8'h00);
        // R5
        @(negedge clk); port_hi = 4'b0100; tick(SYNC + 2);
        chk("R5 change sets", reg_rdata, 8'h01);
        wr(8'h00); tick(4);
        chk("R5 stable no set", reg_rdata[0], 0);
        @(negedge clk); port_hi = 4'b0000; tick(SYNC + 2);
        chk("R5 change back sets", reg_rdata[0], 1);
        wr(8'h00);
        // R6
        @(negedge clk); tmr_ovf = 1; reg_wr = 1; reg_wdata = 8'h00;
        @(negedge clk); tmr_ovf = 0; reg_wr = 0; #1;
        chk("R6 hw wins", reg_rdata[2], 1);
        wr(8'h00);
        // R7 strobe gated
        @(negedge clk); strobe_on = 0;
        wr(8'hA0); pulse_tmr(); tick(12);
        chk("R7 no strobe no req", irq_req, 0);
        // R8 latency
        expect_vector("R8");
        @(negedge clk); strobe_on = 1;
        t0 = -1; t1 = -1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk); #1;
            if (irq_req && t0 < 0) t0 = i;
            if (vec_load && t1 < 0) t1 = i;
        end
        chk("R8 latency", t1 - t0, 3);
        chk("R8 gie cleared flag kept", reg_rdata, 8'h24);
        chk("R8 req dropped", irq_req, 0);
        // R10
        expect_vector("R10");
        @(negedge clk); reti = 1;
        @(negedge clk); reti = 0; #1;
        chk("R10 gie set", reg_rdata[7], 1);
        tick(24);
        chk("R10 revector", exp_q.size(), 0);
        wr(8'h00);
        // R7 write-complete source
        @(negedge clk); nvw_flag = 1;
        wr(8'h80); tick(16);
        chk("R7 wce masked", irq_req, 0);
        expect_vector("R7 wce");
        wr(8'hC0); tick(24);
        chk("R7 wce vector", exp_q.size(), 0);
        chk("R7 wce gie cleared", reg_rdata, 8'h40);
        @(negedge clk); nvw_flag = 0;
        wr(8'h00);
        // R11 / R12 with gie clear
        @(negedge clk); asleep = 1; tick(8);
        wr(8'h20); chk("R11 no wake", wake, 0);
        pulse_tmr(); chk("R11 wake gie0", wake, 1);
        tick(12);
        @(negedge clk); asleep = 0; tick(1);
        chk("R11 wake drops", wake, 0);
        tick(16);
        chk("R12 continue no vector", reg_rdata, 8'h24);
        wr(8'h00);
        // R11 / R12 with gie set
        @(negedge clk); asleep = 1; tick(8);
        wr(8'hA0); pulse_tmr();
        chk("R11 wake gie1", wake, 1);
        tick(16);
        expect_vector("R12");
        @(negedge clk); asleep = 0; tick(28);
        chk("R12 vector after wake", exp_q.size(), 0);
        wr(8'h00); tick(12);
        chk("R12 final reg", reg_rdata, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule